// File: doc/BRIEF.md
# Front-End Event Fragment Checker

This block sits behind a front-end readout link. It receives one 32-bit word on every cycle where `in_valid` is high. While it is idle it waits for the opening control word, 0x51115110. After that word it walks a fixed fragment grammar:

- 16 digitizer groups, each one header word, then N sample words, then one group CRC word;
- a digitizer CRC word;
- a link CRC word;
- the closing control word.

The sample count N comes from `cfg_samples` and is captured when the opening word arrives. N may be any value from 1 to 16.

Along the way the block types every word by its position and checks the type bit (bit 31) against that position. It checks odd parity on header and sample words and decodes each header. It also runs a CCITT CRC over the body of the fragment. When the closing word arrives, it gives a one-cycle `frag_done` pulse with the fragment's status flags and parity-error count. It then goes back to hunting for the next opening word.

Top module: `frag_checker`

## Requirements
- R1: While hunting, every accepted word other than 0x51115110 is ignored: no `frag_done` and no `hdr_valid` result from it.
- R2: A fragment is 1 + 16·(N+2) + 3 accepted words. `frag_done` is high for exactly one cycle, in the cycle after the last word is accepted, and the status outputs are valid in that cycle. After reset `frag_done` and `hdr_valid` are 0.
- R3: `frag_trl_err` is 1 when the word in the closing position is not 0xFFFFFFF0.
- R4: Header and sample words must have odd parity over all 32 bits, with bit 30 as the parity bit. `frag_par_cnt` gives the number of such words in the fragment that fail this check.
- R5: `frag_fmt_err` is 1 in either of these cases:
  - a header-position word has bit 31 = 0, or has bit 17 (a spare bit) set;
  - a sample-position word has bit 31 = 1.
- R6: For every header-position word with bit 31 = 1, `hdr_valid` pulses in the next cycle with the decoded header fields:
  - sample count from bits 29:26;
  - status flags from bits 25:22;
  - variable parity from bits 21:18;
  - mode from bits 16:15;
  - gain from bits 14:12;
  - bunch crossing from bits 11:0.
- R7: `frag_mode_err` is 1 when any header in the fragment carries mode code 2'b11. The codes 00, 01 and 10 are valid.
- R8: `frag_crc_err` compares a computed CRC with bits 15:0 of the link CRC word, and is 1 when they differ.
  - The computed CRC is CCITT: polynomial 0x1021, initial value 0xFFFF, MSB first, no reflection, no output XOR.
  - It covers every word from the first header through the digitizer CRC word, each taken as its upper 16 bits and then its lower 16 bits.
- R9: Cycles with `in_valid` low do not advance the grammar and do not change any result.
- R10: The sample count N is taken from `cfg_samples` when the opening word is accepted. Values 1 through 16 are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Word on `in_word` is accepted this cycle |
| in_word | input | 32 | Link word |
| cfg_samples | input | 5 | Sample words per digitizer group (1..16) |
| frag_done | output | 1 | One-cycle end-of-fragment pulse |
| frag_crc_err | output | 1 | Link CRC mismatch |
| frag_trl_err | output | 1 | Closing word mismatch |
| frag_fmt_err | output | 1 | Type bit or spare bit violation |
| frag_mode_err | output | 1 | A header carried mode 11 |
| frag_par_cnt | output | 9 | Count of parity failures in the fragment |
| hdr_valid | output | 1 | Decoded header fields valid |
| hdr_samples | output | 4 | Header sample-count field |
| hdr_status | output | 4 | Memory parity, single strobe, double strobe, register parity |
| hdr_vpar | output | 4 | Variable parity field |
| hdr_mode | output | 2 | Mode field |
| hdr_gain | output | 3 | Gain field |
| hdr_bcid | output | 12 | Bunch-crossing number |

## Verification
The assertions assume the following about the inputs:
- `in_word` is only meaningful in cycles where `in_valid` is high;
- `cfg_samples` stays within 1..16 while the opening word is accepted.

The stimulus meets both. It changes inputs only away from the sampling edge, sets `cfg_samples` before each opening word, and holds it for the whole fragment. When `in_valid` is low it drives filler words, so any effect of stall cycles shows up at the outputs.

// File: rtl/frag_pkg.sv
package frag_pkg;

    localparam logic [31:0] OPEN_WORD  = 32'h5111_5110;
    localparam logic [31:0] CLOSE_WORD = 32'hFFFF_FFF0;
    localparam logic [15:0] CCITT_POLY = 16'h1021;
    localparam logic [15:0] CCITT_INIT = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_HDR,
        ST_SMP,
        ST_GCRC,
        ST_DCRC,
        ST_LCRC,
        ST_CLOSE
    } fst_e;

    typedef struct packed {
        logic [3:0]  samples;
        logic [3:0]  status;
        logic [3:0]  vpar;
        logic        spare;
        logic [1:0]  mode;
        logic [2:0]  gain;
        logic [11:0] bcid;
    } hdr_fields_t;

    function automatic logic [15:0] ccitt_step16(input logic [15:0] crc_in,
                                                 input logic [15:0] data);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 15; i >= 0; i--) begin
            fb = c[15] ^ data[i];
            c  = {c[14:0], 1'b0} ^ (fb ? CCITT_POLY : 16'h0000);
        end
        return c;
    endfunction

endpackage

// File: rtl/frag_word_check.sv
module frag_word_check
    import frag_pkg::*;
(
    input  logic [31:0] word,
    output logic        type_hdr,
    output logic        par_ok,
    output hdr_fields_t fields
);
    always_comb begin
        type_hdr       = word[31];
        par_ok         = ^word;
        fields.samples = word[29:26];
        fields.status  = word[25:22];
        fields.vpar    = word[21:18];
        fields.spare   = word[17];
        fields.mode    = word[16:15];
        fields.gain    = word[14:12];
        fields.bcid    = word[11:0];
    end
endmodule

// File: rtl/frag_ccitt.sv
module frag_ccitt
    import frag_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [2*HALF_W-1:0] word,
    output logic [15:0]       crc
);
    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr) begin
            crc_d = CCITT_INIT;
        end else if (en) begin
            crc_d = ccitt_step16(ccitt_step16(crc_q, word[2*HALF_W-1:HALF_W]),
                                 word[HALF_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CCITT_INIT;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/frag_checker.sv
module frag_checker
    import frag_pkg::*;
#(
    parameter int GROUPS      = 16,
    parameter int MAX_SAMPLES = 16,
    parameter int SW          = $clog2(MAX_SAMPLES + 1),
    parameter int PAR_W       = $clog2(GROUPS * (MAX_SAMPLES + 1) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_word,
    input  logic [SW-1:0]    cfg_samples,
    output logic             frag_done,
    output logic             frag_crc_err,
    output logic             frag_trl_err,
    output logic             frag_fmt_err,
    output logic             frag_mode_err,
    output logic [PAR_W-1:0] frag_par_cnt,
    output logic             hdr_valid,
    output logic [3:0]       hdr_samples,
    output logic [3:0]       hdr_status,
    output logic [3:0]       hdr_vpar,
    output logic [1:0]       hdr_mode,
    output logic [2:0]       hdr_gain,
    output logic [11:0]      hdr_bcid
);
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    typedef struct packed {
        fst_e             st;
        logic [GW-1:0]    grp;
        logic [SW-1:0]    smp;
        logic [SW-1:0]    n;
        logic [PAR_W-1:0] par_cnt;
        logic             fmt;
        logic             mode;
        logic             crc_bad;
        logic             trl;
        logic             done;
        logic             hv;
        hdr_fields_t      hf;
    } state_t;

    state_t      d, q;
    logic        type_hdr, par_ok;
    hdr_fields_t fields;
    logic        crc_clr, crc_en;
    logic [15:0] crc_val;

    frag_word_check u_word (
        .word     (in_word),
        .type_hdr (type_hdr),
        .par_ok   (par_ok),
        .fields   (fields)
    );

    frag_ccitt #(.HALF_W(16)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .word  (in_word),
        .crc   (crc_val)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.hv    = 1'b0;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        if (in_valid) begin
            unique case (q.st)
                ST_HUNT: begin
                    if (in_word == OPEN_WORD) begin
                        crc_clr   = 1'b1;
                        d.st      = ST_HDR;
                        d.grp     = '0;
                        d.smp     = '0;
                        d.par_cnt = '0;
                        d.fmt     = 1'b0;
                        d.mode    = 1'b0;
                        d.crc_bad = 1'b0;
                        d.trl     = 1'b0;
                        if (cfg_samples == '0)
                            d.n = SW'(1);
                        else if (cfg_samples > SW'(MAX_SAMPLES))
                            d.n = SW'(MAX_SAMPLES);
                        else
                            d.n = cfg_samples;
                    end
                end
                ST_HDR: begin
                    crc_en = 1'b1;
                    if (!par_ok) d.par_cnt = q.par_cnt + PAR_W'(1);
                    if (!type_hdr || fields.spare) d.fmt = 1'b1;
                    if (type_hdr) begin
                        d.hv = 1'b1;
                        d.hf = fields;
                        if (fields.mode == 2'b11) d.mode = 1'b1;
                    end
                    d.smp = '0;
                    d.st  = ST_SMP;
                end
                ST_SMP: begin
                    crc_en = 1'b1;
                    if (!par_ok) d.par_cnt = q.par_cnt + PAR_W'(1);
                    if (type_hdr) d.fmt = 1'b1;
                    if (q.smp == q.n - SW'(1)) begin
                        d.st = ST_GCRC;
                    end else begin
                        d.smp = q.smp + SW'(1);
                    end
                end
                ST_GCRC: begin
                    crc_en = 1'b1;
                    if (q.grp == GW'(GROUPS - 1)) begin
                        d.st = ST_DCRC;
                    end else begin
                        d.grp = q.grp + GW'(1);
                        d.st  = ST_HDR;
                    end
                end
                ST_DCRC: begin
                    crc_en = 1'b1;
                    d.st   = ST_LCRC;
                end
                ST_LCRC: begin
                    d.crc_bad = (crc_val != in_word[15:0]);
                    d.st      = ST_CLOSE;
                end
                ST_CLOSE: begin
                    d.trl  = (in_word != CLOSE_WORD);
                    d.done = 1'b1;
                    d.st   = ST_HUNT;
                end
                default: d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_HUNT;
        end else begin
            q <= d;
        end
    end

    assign frag_done     = q.done;
    assign frag_crc_err  = q.crc_bad;
    assign frag_trl_err  = q.trl;
    assign frag_fmt_err  = q.fmt;
    assign frag_mode_err = q.mode;
    assign frag_par_cnt  = q.par_cnt;
    assign hdr_valid     = q.hv;
    assign hdr_samples   = q.hf.samples;
    assign hdr_status    = q.hf.status;
    assign hdr_vpar      = q.hf.vpar;
    assign hdr_mode      = q.hf.mode;
    assign hdr_gain      = q.hf.gain;
    assign hdr_bcid      = q.hf.bcid;
endmodule

module frag_checker_sva #(
    parameter int GROUPS      = 16,
    parameter int MAX_SAMPLES = 16,
    parameter int PAR_W       = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      in_word,
    input logic             frag_done,
    input logic [PAR_W-1:0] frag_par_cnt,
    input logic             hdr_valid
);
    localparam int PAR_MAX = GROUPS * (MAX_SAMPLES + 1);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frag_done |=> !frag_done); // R2

    AST_DONE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frag_done) |-> $past(in_valid)); // R9

    AST_HDR_TYPED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_valid) |-> ($past(in_valid) && $past(in_word[31]))); // R6

    AST_NO_STALL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> (!frag_done && !hdr_valid)); // R9

    AST_HDR_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(frag_done && hdr_valid)); // R2

    AST_PAR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        frag_done |-> (int'(frag_par_cnt) <= PAR_MAX)); // R4
endmodule

bind frag_checker frag_checker_sva #(
    .GROUPS      (GROUPS),
    .MAX_SAMPLES (MAX_SAMPLES),
    .PAR_W       (PAR_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_word      (in_word),
    .frag_done    (frag_done),
    .frag_par_cnt (frag_par_cnt),
    .hdr_valid    (hdr_valid)
);

// File: tb/frag_checker_tb.sv
module frag_checker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [4:0]  cfg_samples = 5'd7;
    logic        frag_done, frag_crc_err, frag_trl_err, frag_fmt_err, frag_mode_err;
    logic [8:0]  frag_par_cnt;
    logic        hdr_valid;
    logic [3:0]  hdr_samples, hdr_status, hdr_vpar;
    logic [1:0]  hdr_mode;
    logic [2:0]  hdr_gain;
    logic [11:0] hdr_bcid;

    always #(CLK_PERIOD/2) clk = ~clk;

    frag_checker u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .cfg_samples(cfg_samples), .frag_done(frag_done),
        .frag_crc_err(frag_crc_err), .frag_trl_err(frag_trl_err),
        .frag_fmt_err(frag_fmt_err), .frag_mode_err(frag_mode_err),
        .frag_par_cnt(frag_par_cnt), .hdr_valid(hdr_valid),
        .hdr_samples(hdr_samples), .hdr_status(hdr_status), .hdr_vpar(hdr_vpar),
        .hdr_mode(hdr_mode), .hdr_gain(hdr_gain), .hdr_bcid(hdr_bcid)
    );

    typedef struct {
        logic  crc_err, trl_err, fmt_err, mode_err;
        int    par;
        string tag;
    } exp_frag_t;

    typedef struct {
        logic [31:0] w;
        string       tag;
    } exp_hdr_t;

    exp_frag_t frag_q[$];
    exp_hdr_t  hdr_q[$];
    int checks = 0, failures = 0, done_seen = 0, frags_sent = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fix_par(input logic [31:0] w);
        logic [31:0] r;
        r = w;
        r[30] = 1'b0;
        if ((^r) == 1'b0) r[30] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] ref_crc(input logic [15:0] c0, input logic [15:0] data);
        logic [15:0] c;
        c = c0;
        for (int i = 15; i >= 0; i--) begin
            if (c[15] ^ data[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
            else                 c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

    task automatic send(input logic [31:0] w, input int gap);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_word  = 32'h5111_5110;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_word  = 32'hFFFF_FFF0;
        end
    endtask

    // Driver: builds a fragment, pushes expected items, sends it.
    task automatic run_frag(input int n, input int npar, input bit bad_crc,
                            input bit bad_end, input bit fmt_smp, input bit mode11,
                            input bit spare, input int gap, input string tag);
        logic [31:0] ws[$];
        logic [31:0] w;
        logic [15:0] c;
        int par_left;
        exp_frag_t ef;
        exp_hdr_t  eh;
        par_left = npar;
        ws.push_back(32'h5111_5110);
        for (int g = 0; g < 16; g++) begin
            w = 32'h8000_0000;
            w[29:26] = 4'(n);
            w[25:22] = 4'(g);
            w[21:18] = 4'(15 - g);
            w[17]    = (spare && g == 5);
            w[16:15] = (mode11 && g == 3) ? 2'b11 : 2'(g % 3);
            w[14:12] = 3'(g);
            w[11:0]  = 12'(g * 37 + n);
            w = fix_par(w);
            ws.push_back(w);
            eh.w = w; eh.tag = tag;
            hdr_q.push_back(eh);
            for (int s = 0; s < n; s++) begin
                w = fix_par({2'b00, 30'($urandom)});
                if (fmt_smp && g == 7 && s == 0) w = fix_par({1'b1, w[30:0]});
                if (par_left > 0) begin
                    w[30] = ~w[30];
                    par_left--;
                end
                ws.push_back(w);
            end
            ws.push_back($urandom);
        end
        ws.push_back($urandom);
        c = 16'hFFFF;
        for (int i = 1; i < ws.size(); i++) begin
            c = ref_crc(c, ws[i][31:16]);
            c = ref_crc(c, ws[i][15:0]);
        end
        ws.push_back({16'h5A5A, bad_crc ? (c ^ 16'h0100) : c});
        ws.push_back(bad_end ? 32'hFFFF_FFF1 : 32'hFFFF_FFF0);
        ef.crc_err = bad_crc; ef.trl_err = bad_end;
        ef.fmt_err = fmt_smp | spare; ef.mode_err = mode11;
        ef.par = npar; ef.tag = tag;
        frag_q.push_back(ef);
        frags_sent++;
        @(negedge clk);
        cfg_samples = 5'(n);
        foreach (ws[i]) send(ws[i], gap);
        idle(3);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (frag_done) begin
                done_seen++;
                if (frag_q.size() == 0) begin
                    check(1'b0, "R1 unexpected frag_done", 1, 0);
                end else begin
                    exp_frag_t e;
                    e = frag_q.pop_front();
                    check(frag_crc_err == e.crc_err, {"R8 crc_err ", e.tag}, frag_crc_err, e.crc_err);
                    check(frag_trl_err == e.trl_err, {"R3 trl_err ", e.tag}, frag_trl_err, e.trl_err);
                    check(frag_fmt_err == e.fmt_err, {"R5 fmt_err ", e.tag}, frag_fmt_err, e.fmt_err);
                    check(frag_mode_err == e.mode_err, {"R7 mode_err ", e.tag}, frag_mode_err, e.mode_err);
                    check(int'(frag_par_cnt) == e.par, {"R4 par_cnt ", e.tag}, frag_par_cnt, e.par);
                end
            end
            if (hdr_valid) begin
                if (hdr_q.size() == 0) begin
                    check(1'b0, "R1 unexpected hdr_valid", 1, 0);
                end else begin
                    exp_hdr_t h;
                    logic [31:0] x;
                    h = hdr_q.pop_front();
                    x = h.w;
                    check({hdr_samples, hdr_status, hdr_vpar, hdr_mode, hdr_gain, hdr_bcid} ==
                          {x[29:26], x[25:22], x[21:18], x[16:15], x[14:12], x[11:0]},
                          {"R6 header fields ", h.tag},
                          {hdr_samples, hdr_status, hdr_vpar, hdr_mode, hdr_gain, hdr_bcid},
                          {x[29:26], x[25:22], x[21:18], x[16:15], x[14:12], x[11:0]});
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", done_seen, frags_sent);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(frag_done == 1'b0, "R2 reset frag_done", frag_done, 0);
        check(hdr_valid == 1'b0, "R2 reset hdr_valid", hdr_valid, 0);
        rst_n = 1'b1;
        // R1: garbage while hunting
        send(32'h1234_5678, 0);
        send(32'hFFFF_FFF0, 0);
        send(32'h8000_0001, 0);
        idle(4);
        check(done_seen == 0, "R1 hunt ignores words", done_seen, 0);
        run_frag(7, 0, 0, 0, 0, 0, 0, 0, "R2 clean N=7");
        run_frag(9, 0, 0, 0, 0, 0, 0, 2, "R9 stalls N=9");
        run_frag(7, 3, 0, 0, 0, 0, 0, 0, "R4 three parity errs");
        run_frag(7, 0, 1, 0, 0, 0, 0, 0, "R8 bad link crc");
        run_frag(7, 0, 0, 1, 0, 0, 0, 0, "R3 bad close word");
        run_frag(5, 0, 0, 0, 1, 0, 0, 0, "R5 sample typed as header");
        run_frag(5, 0, 0, 0, 0, 0, 1, 0, "R5 spare bit set");
        run_frag(4, 0, 0, 0, 0, 1, 0, 1, "R7 mode 11");
        run_frag(1, 2, 0, 0, 0, 0, 0, 0, "R10 N=1");
        run_frag(16, 0, 0, 0, 0, 0, 0, 0, "R10 N=16");
        idle(5);
        check(done_seen == frags_sent, "R2 one done per fragment", done_seen, frags_sent);
        check(frag_q.size() == 0, "R2 fragment results drained", frag_q.size(), 0);
        check(hdr_q.size() == 0, "R6 header results drained", hdr_q.size(), 0);
        finish_run();
    end
endmodule